// File: doc/BRIEF.md
# E1 Time Slot 0 Regenerator with CRC-4

This block sits in the transmit path of a 2048 kbit/s E1 stream that is only partly used for payload. The stream arrives one byte per strobe, and each byte comes with its time-slot index (0 to 31). When fewer than 32 payload slots are configured, the block discards the incoming slot-0 byte and writes a fresh one. Even frames get the frame-alignment word. Odd frames get the service word, which carries the remote-alarm bit and the spare bits. Slots 1 to 31 always pass through unchanged.

The first bit of every slot-0 byte is the international bit. With CRC-4 off, it is copied from the input. With CRC-4 on, it carries a generated 16-frame multiframe made of two 8-frame halves:

- The even frames carry the four check bits of the previous half.
- Odd frames 1 to 11 carry the fixed alignment pattern.
- Frames 13 and 15 carry error-report bits. These are driven by pulses from a separate receive checker, each pulse marking an errored incoming half-multiframe.

Top module: `e1_ts0_regen`

## Requirements
- R1: A byte whose slot index is not 0 leaves unchanged. When `cfg_nslots` is 32, every byte leaves unchanged, including slot 0.
- R2: With `cfg_nslots` below 32, the slot-0 byte of an even frame has bits 6..0 equal to 0011011 (binary). Bit 7 is sent first.
- R3: With `cfg_nslots` below 32, the slot-0 byte of an odd frame has bit 6 equal to 1 and bits 4..0 equal to 11111.
- R4: Bit 5 of an odd-frame slot-0 byte is 1 exactly when, at that strobe, LOS, AIS or LFA is high and its own mask input is low. Otherwise it is 0.
- R5: With `cfg_crc_en` low, bit 7 of every regenerated slot-0 byte equals bit 7 of the input byte.
- R6: Frame numbering starts at 0 with the first slot-0 strobe after reset and wraps every 16 frames. With CRC-4 on, bit 7 in odd frames 1, 3, 5, 7, 9 and 11 is 0, 0, 1, 0, 1, 1 in that order.
- R7: With CRC-4 on, bit 7 of even frames 0, 2, 4, 6 (and 8, 10, 12, 14) carries C1..C4 of the previous half-multiframe, C1 first. That CRC uses x^4+x+1 and is computed MSB-first over the 256 output bytes of that half, with bit 7 of its even-frame slot-0 bytes taken as 0. Bytes before the first slot 0 are excluded. The first half after reset carries C bits of 0.
- R8: With CRC-4 on, bit 7 of frames 13 and 15 is 0 if an error pulse is pending, and 1 otherwise. Each such slot consumes one pending pulse. At most 2 pulses are held; further pulses are dropped. A pulse in the same cycle as that slot counts for a later one. The pending count drains in frames 13 and 15 in every mode.
- R9: `out_vld` follows `in_vld` one clock later. `out_data` holds its value when no byte arrives. After reset both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Byte strobe |
| in_slot | input | 5 | Time-slot index of the byte |
| in_data | input | 8 | Input byte, bit 7 first on line |
| cfg_nslots | input | 6 | Configured payload slot count (1..32) |
| cfg_crc_en | input | 1 | CRC-4 multiframe generation enable |
| alm_los | input | 1 | Loss of signal level |
| alm_ais | input | 1 | Alarm indication signal level |
| alm_lfa | input | 1 | Loss of frame alignment level |
| msk_los | input | 1 | Stops LOS from setting the A bit |
| msk_ais | input | 1 | Stops AIS from setting the A bit |
| msk_lfa | input | 1 | Stops LFA from setting the A bit |
| rx_smf_err | input | 1 | Pulse: one errored incoming half-multiframe |
| out_vld | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |

## Verification
The bench builds the block with its defaults: 32 slots and a 16-frame multiframe. Several complete multiframes therefore run back to back, so each check-bit set has to carry across both halves and across the multiframe wrap. It also sweeps all 64 combinations of alarm levels and masks, one frame each. It starts the stream mid-frame, so bytes ahead of the first slot 0 must stay out of the checksum. It also covers:
- queued error pulses that hit the saturation limit;
- a pulse that coincides with an error-report slot;
- strobe gaps.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;

  localparam logic [6:0] ALIGN_TAIL = 7'b0011011;
  localparam logic [5:0] MF_PATTERN = 6'b001011;

  function automatic logic [3:0] crc4_byte(input logic [3:0] c_in, input logic [7:0] b);
    logic [3:0] c;
    logic       fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[3] ^ b[i];
      c  = {c[2:0], 1'b0} ^ {2'b00, fb, fb};
    end
    return c;
  endfunction

endpackage

// File: rtl/e1_mf_track.sv
module e1_mf_track #(
  parameter int FRAMES = 16,
  parameter int SLOT_W = 5,
  localparam int FR_W  = $clog2(FRAMES),
  localparam int SMF_W = $clog2(FRAMES / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [SLOT_W-1:0] slot,
  output logic [FR_W-1:0]   cur_frame,
  output logic              active,
  output logic              smf_start
);

  logic [FR_W-1:0] fnext_q, fnext_d;
  logic            sync_q, sync_d;
  logic            is0;

  assign is0       = (slot == '0);
  assign cur_frame = is0 ? fnext_q
                   : ((fnext_q == '0) ? FR_W'(FRAMES - 1) : fnext_q - 1'b1);
  assign active    = sync_q | is0;
  assign smf_start = strobe & is0 & (fnext_q[SMF_W-1:0] == '0);

  always_comb begin
    fnext_d = fnext_q;
    sync_d  = sync_q;
    if (strobe && is0) begin
      fnext_d = (fnext_q == FR_W'(FRAMES - 1)) ? '0 : fnext_q + 1'b1;
      sync_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fnext_q <= '0;
      sync_q  <= 1'b0;
    end else begin
      fnext_q <= fnext_d;
      sync_q  <= sync_d;
    end
  end

  p_sync_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> sync_q);

  p_sync_on_slot0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && is0) |=> (sync_q && fnext_q != $past(fnext_q)));

endmodule

// File: rtl/e1_crc4_gen.sv
module e1_crc4_gen
  import e1_ts0_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic       smf_start,
  input  logic [7:0] byte_in,
  output logic [3:0] c_bits
);

  logic [3:0] acc_q, acc_d;
  logic [3:0] hold_q, hold_d;

  assign c_bits = smf_start ? acc_q : hold_q;

  always_comb begin
    acc_d  = acc_q;
    hold_d = hold_q;
    if (acc_en) begin
      acc_d = crc4_byte(smf_start ? 4'h0 : acc_q, byte_in);
    end
    if (smf_start) begin
      hold_d = acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hold_q <= '0;
    end else begin
      acc_q  <= acc_d;
      hold_q <= hold_d;
    end
  end

  p_acc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(acc_q));

  p_hold_only_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !smf_start |=> $stable(hold_q));

endmodule

// File: rtl/e1_ebit_queue.sv
module e1_ebit_queue #(
  parameter int PEND_MAX = 2,
  localparam int CW = $clog2(PEND_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_pulse,
  input  logic take,
  output logic e_bit
);

  logic [CW-1:0] cnt_q, cnt_d, drained;

  assign e_bit = (cnt_q == '0);

  always_comb begin
    drained = cnt_q;
    if (take && cnt_q != '0) begin
      drained = cnt_q - 1'b1;
    end
    cnt_d = drained;
    if (err_pulse && drained < CW'(PEND_MAX)) begin
      cnt_d = drained + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  p_pend_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PEND_MAX));

  p_err_registers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !take) |=> !e_bit);

endmodule

// File: rtl/e1_ts0_regen.sv
module e1_ts0_regen
  import e1_ts0_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int FRAMES   = 16,
  parameter int PEND_MAX = 2,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int CNT_W   = $clog2(SLOTS + 1),
  localparam int FR_W    = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [7:0]        in_data,
  input  logic [CNT_W-1:0]  cfg_nslots,
  input  logic              cfg_crc_en,
  input  logic              alm_los,
  input  logic              alm_ais,
  input  logic              alm_lfa,
  input  logic              msk_los,
  input  logic              msk_ais,
  input  logic              msk_lfa,
  input  logic              rx_smf_err,
  output logic              out_vld,
  output logic [7:0]        out_data
);

  logic [FR_W-1:0] frame;
  logic            active, smf_start;
  logic [3:0]      c_bits;
  logic            e_bit, take;
  logic            structured, is0, even, a_bit, si;
  logic [7:0]      ts0_word, word, crc_byte;
  logic            vld_d;
  logic [7:0]      data_d;

  e1_mf_track #(.FRAMES(FRAMES), .SLOT_W(SLOT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .strobe(in_vld), .slot(in_slot),
    .cur_frame(frame), .active(active), .smf_start(smf_start)
  );

  e1_crc4_gen u_crc (
    .clk(clk), .rst_n(rst_n), .acc_en(in_vld & active),
    .smf_start(smf_start), .byte_in(crc_byte), .c_bits(c_bits)
  );

  e1_ebit_queue #(.PEND_MAX(PEND_MAX)) u_ebit (
    .clk(clk), .rst_n(rst_n), .err_pulse(rx_smf_err), .take(take), .e_bit(e_bit)
  );

  assign structured = (cfg_nslots < CNT_W'(SLOTS));
  assign is0        = (in_slot == '0);
  assign even       = ~frame[0];
  assign a_bit      = (alm_los & ~msk_los) | (alm_ais & ~msk_ais) | (alm_lfa & ~msk_lfa);
  assign take       = in_vld & is0 & ((frame == FR_W'(13)) | (frame == FR_W'(15)));

  always_comb begin
    si = in_data[7];
    if (cfg_crc_en) begin
      if (even) begin
        si = c_bits[2'd3 - frame[2:1]];
      end else if (frame[3:1] >= 3'd6) begin
        si = e_bit;
      end else begin
        si = MF_PATTERN[3'd5 - frame[3:1]];
      end
    end
  end

  assign ts0_word = even ? {si, ALIGN_TAIL} : {si, 1'b1, a_bit, 5'b11111};
  assign word     = (structured && is0) ? ts0_word : in_data;
  assign crc_byte = (is0 && even) ? {1'b0, word[6:0]} : word;

  always_comb begin
    vld_d  = in_vld;
    data_d = out_data;
    if (in_vld) begin
      data_d = word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld  <= vld_d;
      out_data <= data_d;
    end
  end

  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (!is0 || !structured)) |=> (out_data == $past(in_data)));

  p_align_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && is0 && structured && even) |=> (out_data[6:0] == 7'b0011011));

  p_service_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && is0 && structured && !even) |=> (out_data[6] && out_data[4:0] == 5'h1f));

  p_abit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && is0 && structured && !even) |=>
      (out_data[5] == $past((alm_los && !msk_los) || (alm_ais && !msk_ais) || (alm_lfa && !msk_lfa))));

  p_si_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && is0 && structured && !cfg_crc_en) |=> (out_data[7] == $past(in_data[7])));

  p_vld_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(out_data)));

endmodule

// File: tb/tb_e1_ts0_regen.sv
`timescale 1ns/1ps
module tb_e1_ts0_regen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_vld;
  logic [4:0] in_slot;
  logic [7:0] in_data;
  logic [5:0] cfg_nslots;
  logic       cfg_crc_en;
  logic       alm_los, alm_ais, alm_lfa;
  logic       msk_los, msk_ais, msk_lfa;
  logic       rx_smf_err;
  logic       out_vld;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  e1_ts0_regen dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_slot(in_slot), .in_data(in_data),
    .cfg_nslots(cfg_nslots), .cfg_crc_en(cfg_crc_en),
    .alm_los(alm_los), .alm_ais(alm_ais), .alm_lfa(alm_lfa),
    .msk_los(msk_los), .msk_ais(msk_ais), .msk_lfa(msk_lfa),
    .rx_smf_err(rx_smf_err), .out_vld(out_vld), .out_data(out_data)
  );

  // reference state
  int         m_fnext = 0;
  bit         m_sync  = 0;
  logic [3:0] m_acc   = 4'h0;
  logic [3:0] m_hold  = 4'h0;
  int         m_pend  = 0;
  logic [7:0] last_out = 8'h00;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [3:0] ref_crc(input logic [3:0] c, input logic [7:0] b);
    logic [3:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      if (r[3] != b[k]) r = (r << 1) ^ 4'b0011;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0];
  endfunction

  // called at a negedge; returns at the following negedge after checking
  task automatic do_byte(input bit vld, input int slot, input logic [7:0] din, input bit err);
    logic [7:0] exp;
    logic [3:0] src;
    logic [7:0] cb;
    bit is0, act, si, ab, reg0;
    int f;
    string si_req;
    bit pat [6] = '{0, 0, 1, 0, 1, 1};
    in_vld = vld; in_slot = 5'(slot); in_data = din; rx_smf_err = err;
    exp = din; is0 = (slot == 0); f = 0; reg0 = 0; si_req = "R5";
    if (vld) begin
      f   = is0 ? m_fnext : (m_fnext + 15) % 16;
      act = m_sync || is0;
      reg0 = is0 && (cfg_nslots < 32);
      if (reg0) begin
        ab = (alm_los && !msk_los) || (alm_ais && !msk_ais) || (alm_lfa && !msk_lfa);
        if (!cfg_crc_en) begin
          si = din[7]; si_req = "R5";
        end else if (f % 2 == 0) begin
          src = (f % 8 == 0) ? m_acc : m_hold;
          si = src[3 - ((f / 2) % 4)]; si_req = "R7";
        end else if (f == 13 || f == 15) begin
          si = (m_pend == 0); si_req = "R8";
        end else begin
          si = pat[(f - 1) / 2]; si_req = "R6";
        end
        exp = (f % 2 == 0) ? {si, 7'b0011011} : {si, 1'b1, ab, 5'b11111};
      end
      if (is0 && (f == 13 || f == 15) && m_pend > 0) m_pend--;
      if (act) begin
        cb = (is0 && f % 2 == 0) ? {1'b0, exp[6:0]} : exp;
        if (is0 && f % 8 == 0) begin
          m_hold = m_acc;
          m_acc  = ref_crc(4'h0, cb);
        end else begin
          m_acc = ref_crc(m_acc, cb);
        end
      end
      if (is0) begin
        m_fnext = (m_fnext + 1) % 16;
        m_sync = 1;
      end
    end
    if (err && m_pend < 2) m_pend++;
    @(posedge clk);
    @(negedge clk);
    if (!vld) begin
      chk("R9 idle vld", out_vld, 0);
      chk("R9 idle hold", out_data, last_out);
    end else begin
      chk("R9 vld", out_vld, 1);
      if (!reg0) begin
        chk("R1 pass", out_data, exp);
      end else begin
        if (f % 2 == 0) begin
          chk("R2 align", out_data[6:0], exp[6:0]);
        end else begin
          chk("R3 service", {out_data[6], out_data[4:0]}, {exp[6], exp[4:0]});
          chk("R4 abit", out_data[5], exp[5]);
        end
        chk(si_req, out_data[7], exp[7]);
      end
      last_out = out_data;
    end
  endtask

  task automatic run_frame(input int nf_err_frame, input int err_slot);
    for (int s = 0; s < 32; s++) begin
      do_byte(1'b1, s, next_rand(), (nf_err_frame != 0) && (s == err_slot));
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 0; in_slot = 0; in_data = 0;
    cfg_nslots = 6'd24; cfg_crc_en = 1'b1;
    alm_los = 0; alm_ais = 0; alm_lfa = 0;
    msk_los = 0; msk_ais = 0; msk_lfa = 0; rx_smf_err = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset vld", out_vld, 0);
    chk("R9 reset data", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // unsynced tail of a frame: excluded from the first checksum (R7)
    for (int s = 28; s < 32; s++) do_byte(1'b1, s, next_rand(), 1'b0);

    // three multiframes, CRC-4 on, with queued error pulses (R6 R7 R8)
    for (int f = 0; f < 48; f++) begin
      int es;
      es = -1;
      if (f == 2) es = 5;
      if (f == 9) es = 7;
      if (f == 10) es = 3;
      if (f == 29) es = 0;
      if (f == 40 || f == 41 || f == 42) es = 1;
      run_frame(es >= 0 ? 1 : 0, es);
    end

    // alarm and mask sweep, one frame each (R4)
    for (int k = 0; k < 64; k++) begin
      alm_los = k[0]; alm_ais = k[1]; alm_lfa = k[2];
      msk_los = k[3]; msk_ais = k[4]; msk_lfa = k[5];
      run_frame(0, 0);
    end
    alm_los = 1; alm_ais = 0; alm_lfa = 0;
    msk_los = 0; msk_ais = 0; msk_lfa = 0;

    // CRC-4 off: international bit copied (R5)
    cfg_crc_en = 1'b0;
    for (int f = 0; f < 32; f++) run_frame(0, 0);

    // all slots selected: full transparency (R1)
    cfg_nslots = 6'd32;
    for (int f = 0; f < 16; f++) run_frame(0, 0);

    // back to structured with strobe gaps (R9)
    cfg_nslots = 6'd31; cfg_crc_en = 1'b1; alm_los = 0;
    for (int f = 0; f < 32; f++) begin
      for (int s = 0; s < 32; s++) begin
        if (s % 7 == 3) do_byte(1'b0, 9, 8'h5A, 1'b0);
        do_byte(1'b1, s, next_rand(), (f == 4 && s == 9));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule